// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block turns a small set of level-sensitive device interrupt lines into message writes aimed at a processor. Each input has two entries in an internal table. The low entry holds a 6-bit vector, a mask bit and trigger/polarity flags. The high entry holds the destination in a packed form, which the block unpacks into a 32-bit message address. Software never addresses the table directly. It writes a table index into a select register and then reads or writes the chosen entry through a window register. A version word sits at one fixed index of the same window.

When an unmasked input with a destination rises, the block records its vector in a pending vector. This happens only if the vector's bit was clear. In that case the block also queues one message: the unpacked destination address, with the vector as data. The message goes out on a valid/ready port. Messages from several inputs wait in turn while the port is busy. The handler acknowledges an interrupt by writing its vector to an end-of-interrupt register. This clears every pending bit that belongs to an entry carrying that vector. A standalone combinational block packs a plain address into the table format, so that software models and benches can build high entries.

Top module: `irq_redirect`

## Requirements
- R1: Register offsets are select 0x800, window 0x810 and end-of-interrupt 0x840, decoded on exact 12-bit address match. The select register is 8 bits wide, reads back zero-extended, and resets to 0. Reads at any other offset, and at 0x840, return 0. Read data is combinational from the current address.
- R2: With select 0x01, the window reads 0x0020_0001. The upper 16 bits give the table size (0x10 + 2 × inputs = 32), and the low bits are 1.
- R3: For input n, the low entry is at table index 0x10+2n and the high entry at 0x11+2n. A window write updates only the selected entry, and the new value reads back from the next cycle on.
- R4: Window reads with select 0x00, 0x02–0x0F or any index at or above 0x20 return 0. Window writes to those indices, and to 0x01, change nothing.
- R5: After reset, the low entry of input n is 0x0001_A000 | (n+2). This means mask (bit 16), level (bit 15) and active-low (bit 13) are set, with vector n+2. Every high entry holds the packed default destination 0xB0FF_0000, which unpacks to 0xFFFB_0000. The pending vector is 0 and msg_valid is low.
- R6: An unmasked input (bit 16 clear) with a nonzero high entry rises. The pending bit shows at the first clock edge that samples the input high. msg_valid rises at the next edge, with address = unpacked high entry and data = low entry bits 5:0.
- R7: A rising input that is masked, or whose high entry is 0, sends no message and leaves its pending bit clear.
- R8: The pending bit is chosen by vector bits 2:0. A message is queued only when that bit goes from 0 to 1. A rise while the bit is already set sends nothing.
- R9: A falling input clears the pending bit selected by its own vector.
- R10: A write to 0x840 masks the data to 6 bits. For every input whose vector (low bits 5:0) equals that value, the pending bit chosen by the vector's bits 2:0 clears at that write's edge. A value that matches no entry changes nothing.
- R11: Unpacking a high entry p gives {4'hF, p[23:16], p[31:24], 12'h000}. The separate pack block gives {a[19:12], a[27:20], 16'h0000}, so unpacking a packed address restores it whenever its top nibble is F and its low 12 bits are 0.
- R12: While msg_valid is high and msg_ready low, address and data hold. When several messages wait, the lowest input index goes first, one per handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_in | input | 8 | Level interrupt inputs |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted by the fabric |
| msg_addr | output | 32 | Message destination address |
| msg_data | output | 32 | Message data (vector) |
| pend_vec | output | 8 | Pending vector bits |

## Verification
Reads are combinational, so they are sampled one time unit after the address settles, away from any edge. A window or select write counts from the edge that takes the strobe, and the bench reads it back at the falling edge after that. Input events drive on a falling edge. The pending vector is then checked just after the first rising edge, and msg_valid with its address and data just after the second. The end-of-interrupt clear is checked right after the edge that takes the write. Checks that nothing happens, for masked, destination-less or already pending inputs, wait three edges before sampling.

// File: rtl/irc_pkg.sv
package irc_pkg;

    localparam int REG_AW   = 12;
    localparam int DW       = 32;
    localparam int VEC_W    = 6;
    localparam int MASK_BIT = 16;
    localparam int LVL_BIT  = 15;
    localparam int POL_BIT  = 13;
    localparam int TBL_BASE = 16;

    localparam logic [REG_AW-1:0] OFS_SEL = 12'h800;
    localparam logic [REG_AW-1:0] OFS_WIN = 12'h810;
    localparam logic [REG_AW-1:0] OFS_EOI = 12'h840;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SEL,
        ACC_WIN,
        ACC_EOI
    } acc_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } msg_t;

    function automatic logic [DW-1:0] dest_unpack(input logic [DW-1:0] p);
        return {4'hF, p[23:16], p[31:24], 12'h000};
    endfunction

    function automatic logic [DW-1:0] dest_pack(input logic [DW-1:0] a);
        return {a[19:12], a[27:20], 16'h0000};
    endfunction

endpackage

// File: rtl/irc_dest_pack.sv
module irc_dest_pack
    import irc_pkg::*;
(
    input  logic [DW-1:0] addr_i,
    output logic [DW-1:0] packed_o
);
    assign packed_o = dest_pack(addr_i);
endmodule

// File: rtl/irc_regfile.sv
module irc_regfile
    import irc_pkg::*;
#(
    parameter int NUM_IN = 8,
    parameter int SEL_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [REG_AW-1:0]          addr,
    input  logic [DW-1:0]              wdata,
    input  logic [DW-1:0]              rst_high,
    output logic [DW-1:0]              rdata,
    output logic [NUM_IN-1:0][DW-1:0]  low_tbl,
    output logic [NUM_IN-1:0][DW-1:0]  high_tbl,
    output logic                       eoi_valid,
    output logic [VEC_W-1:0]           eoi_vec
);
    localparam int TBL_DEPTH = TBL_BASE + 2 * NUM_IN;
    localparam logic [DW-1:0] VERSION = {16'(TBL_DEPTH), 16'h0001};
    localparam logic [DW-1:0] LOW_FLAGS =
        DW'((1 << MASK_BIT) | (1 << LVL_BIT) | (1 << POL_BIT));

    acc_e             acc;
    logic [SEL_W-1:0] sel;
    logic             win_wr;

    always_comb begin
        unique case (addr)
            OFS_SEL: acc = ACC_SEL;
            OFS_WIN: acc = ACC_WIN;
            OFS_EOI: acc = ACC_EOI;
            default: acc = ACC_NONE;
        endcase
    end

    assign win_wr    = wr && (acc == ACC_WIN);
    assign eoi_valid = wr && (acc == ACC_EOI);
    assign eoi_vec   = wdata[VEC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)                          sel <= '0;
        else if (wr && (acc == ACC_SEL))  sel <= wdata[SEL_W-1:0];
    end

    for (genvar n = 0; n < NUM_IN; n++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                low_tbl[n]  <= LOW_FLAGS | DW'(n + 2);
                high_tbl[n] <= rst_high;
            end else if (win_wr) begin
                if (sel == SEL_W'(TBL_BASE + 2 * n))     low_tbl[n]  <= wdata;
                if (sel == SEL_W'(TBL_BASE + 2 * n + 1)) high_tbl[n] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (acc)
            ACC_SEL: rdata = DW'(sel);
            ACC_WIN: begin
                if (sel == SEL_W'(1)) rdata = VERSION;
                for (int n = 0; n < NUM_IN; n++) begin
                    if (sel == SEL_W'(TBL_BASE + 2 * n))     rdata = low_tbl[n];
                    if (sel == SEL_W'(TBL_BASE + 2 * n + 1)) rdata = high_tbl[n];
                end
            end
            default: rdata = '0;
        endcase
    end

    // R4
    oob_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (win_wr && (32'(sel) >= 32'(TBL_DEPTH) || 32'(sel) < 32'(TBL_BASE)))
        |=> ($stable(low_tbl) && $stable(high_tbl)));

endmodule

// File: rtl/irc_pend.sv
module irc_pend
    import irc_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_IN-1:0]          irq_in,
    input  logic [NUM_IN-1:0][DW-1:0]  low_tbl,
    input  logic [NUM_IN-1:0][DW-1:0]  high_tbl,
    input  logic                       eoi_valid,
    input  logic [VEC_W-1:0]           eoi_vec,
    input  logic [NUM_IN-1:0]          grant,
    output logic [NUM_IN-1:0]          pend,
    output logic [NUM_IN-1:0]          req
);
    localparam int IDX_W = $clog2(NUM_IN);

    logic [NUM_IN-1:0] irq_q, rise, fall, pend_nx, req_nx, armed;

    assign rise = irq_in & ~irq_q;
    assign fall = ~irq_in & irq_q;

    for (genvar n = 0; n < NUM_IN; n++) begin : g_arm
        assign armed[n] = !low_tbl[n][MASK_BIT] && (high_tbl[n] != '0);
    end

    always_comb begin
        pend_nx = pend;
        req_nx  = req & ~grant;
        if (eoi_valid) begin
            for (int n = 0; n < NUM_IN; n++)
                if (low_tbl[n][VEC_W-1:0] == eoi_vec)
                    pend_nx[low_tbl[n][IDX_W-1:0]] = 1'b0;
        end
        for (int n = 0; n < NUM_IN; n++) begin
            if (fall[n] || (rise[n] && !armed[n])) begin
                pend_nx[low_tbl[n][IDX_W-1:0]] = 1'b0;
            end else if (rise[n]) begin
                pend_nx[low_tbl[n][IDX_W-1:0]] = 1'b1;
                if (!pend[low_tbl[n][IDX_W-1:0]]) req_nx[n] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            pend  <= '0;
            req   <= '0;
        end else begin
            irq_q <= irq_in;
            pend  <= pend_nx;
            req   <= req_nx;
        end
    end

    // R5
    pend_clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend == '0));

    // R8
    pend_set_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(pend & ~$past(pend))) |-> $past(|(irq_in & ~irq_q)));

endmodule

// File: rtl/irc_msg_out.sv
module irc_msg_out
    import irc_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_IN-1:0]          req,
    input  logic [NUM_IN-1:0][DW-1:0]  low_tbl,
    input  logic [NUM_IN-1:0][DW-1:0]  high_tbl,
    input  logic                       msg_ready,
    output logic [NUM_IN-1:0]          grant,
    output logic                       msg_valid,
    output logic [DW-1:0]              msg_addr,
    output logic [DW-1:0]              msg_data
);
    localparam int IDX_W = $clog2(NUM_IN);

    logic [IDX_W-1:0] pick;
    logic             load;
    msg_t             msg_q;

    always_comb begin
        pick = '0;
        for (int n = NUM_IN - 1; n >= 0; n--)
            if (req[n]) pick = IDX_W'(n);
    end

    assign load  = (|req) && (!msg_valid || msg_ready);
    assign grant = load ? (NUM_IN'(1) << pick) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_q     <= '0;
        end else if (load) begin
            msg_valid  <= 1'b1;
            msg_q.addr <= dest_unpack(high_tbl[pick]);
            msg_q.data <= DW'(low_tbl[pick][VEC_W-1:0]);
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    assign msg_addr = msg_q.addr;
    assign msg_data = msg_q.data;

    // R12
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R11
    msg_addr_form_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr[31:28] == 4'hF && msg_addr[11:0] == 12'h000));

endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
    import irc_pkg::*;
#(
    parameter int          NUM_IN       = 8,
    parameter int          SEL_W        = 8,
    parameter logic [31:0] DEFAULT_DEST = 32'hFFFB_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [31:0]       msg_addr,
    output logic [31:0]       msg_data,
    output logic [NUM_IN-1:0] pend_vec
);
    logic [NUM_IN-1:0][DW-1:0] low_tbl, high_tbl;
    logic [DW-1:0]             rst_high;
    logic                      eoi_valid;
    logic [VEC_W-1:0]          eoi_vec;
    logic [NUM_IN-1:0]         req, grant;

    irc_dest_pack u_pack (
        .addr_i   (DEFAULT_DEST),
        .packed_o (rst_high)
    );

    irc_regfile #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_regs (
        .clk, .rst,
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rst_high  (rst_high),
        .rdata     (reg_rdata),
        .low_tbl   (low_tbl),
        .high_tbl  (high_tbl),
        .eoi_valid (eoi_valid),
        .eoi_vec   (eoi_vec)
    );

    irc_pend #(.NUM_IN(NUM_IN)) u_pend (
        .clk, .rst,
        .irq_in    (irq_in),
        .low_tbl   (low_tbl),
        .high_tbl  (high_tbl),
        .eoi_valid (eoi_valid),
        .eoi_vec   (eoi_vec),
        .grant     (grant),
        .pend      (pend_vec),
        .req       (req)
    );

    irc_msg_out #(.NUM_IN(NUM_IN)) u_msg (
        .clk, .rst,
        .req       (req),
        .low_tbl   (low_tbl),
        .high_tbl  (high_tbl),
        .msg_ready (msg_ready),
        .grant     (grant),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

endmodule

// File: tb/irq_redirect_test.sv
module irq_redirect_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_in = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [31:0] msg_addr, msg_data;
    logic [7:0]  pend_vec;
    logic [31:0] pk_a = '0;
    logic [31:0] pk_p;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_redirect uut (
        .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .irq_in, .msg_valid, .msg_ready, .msg_addr, .msg_data, .pend_vec
    );

    irc_dest_pack pk (.addr_i(pk_a), .packed_o(pk_p));

    // row: {write, offset, data, expected read}
    localparam int NV = 22;
    localparam logic [76:0] VECS [NV] = '{
        {1'b0, 12'h800, 32'h0, 32'h0000_0000},   // R1 select reset value
        {1'b1, 12'h800, 32'h1, 32'h0},
        {1'b0, 12'h800, 32'h0, 32'h0000_0001},   // R1 select readback
        {1'b0, 12'h810, 32'h0, 32'h0020_0001},   // R2 version word
        {1'b1, 12'h810, 32'h1234, 32'h0},
        {1'b0, 12'h810, 32'h0, 32'h0020_0001},   // R4 version write ignored
        {1'b1, 12'h800, 32'h10, 32'h0},
        {1'b0, 12'h810, 32'h0, 32'h0001_A002},   // R5 low entry input 0
        {1'b1, 12'h800, 32'h1E, 32'h0},
        {1'b0, 12'h810, 32'h0, 32'h0001_A009},   // R5 low entry input 7
        {1'b1, 12'h800, 32'h1F, 32'h0},
        {1'b0, 12'h810, 32'h0, 32'hB0FF_0000},   // R5 high entry input 7
        {1'b1, 12'h800, 32'h20, 32'h0},
        {1'b1, 12'h810, 32'hDEAD, 32'h0},
        {1'b0, 12'h810, 32'h0, 32'h0000_0000},   // R4 past table end
        {1'b1, 12'h800, 32'h05, 32'h0},
        {1'b0, 12'h810, 32'h0, 32'h0000_0000},   // R4 unused low index
        {1'b1, 12'h800, 32'h13, 32'h0},
        {1'b1, 12'h810, 32'h1234_5678, 32'h0},
        {1'b0, 12'h810, 32'h0, 32'h1234_5678},   // R3 high entry input 1
        {1'b0, 12'h840, 32'h0, 32'h0000_0000},   // R1 EOI reads 0
        {1'b0, 12'h900, 32'h0, 32'h0000_0000}    // R1 unmapped offset
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        irq_in = '0;
        msg_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wtbl(input logic [7:0] idx, input logic [31:0] d);
        wreg(12'h800, 32'(idx));
        wreg(12'h810, d);
    endtask

    function automatic logic [31:0] unpk(input logic [31:0] p);
        return {4'hF, p[23:16], p[31:24], 12'h000};
    endfunction

    initial begin : wdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        do_reset();

        // R5 reset state at the ports
        #1;
        check("R5 pend after reset", 32'(pend_vec), 32'h0);
        check("R5 msg_valid after reset", 32'(msg_valid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][76]) begin
                wreg(VECS[i][75:64], VECS[i][63:32]);
            end else begin
                @(negedge clk);
                rreg(VECS[i][75:64], rd);
                check($sformatf("R1..R5 table row %0d", i), rd, VECS[i][31:0]);
            end
        end
        // R3 neighbour low entry of input 1 untouched
        wreg(12'h800, 32'h12);
        rreg(12'h810, rd);
        check("R3 neighbour unchanged", rd, 32'h0001_A003);
        // R4 table untouched by out-of-range write
        wreg(12'h800, 32'h1F);
        rreg(12'h810, rd);
        check("R4 high entry kept", rd, 32'hB0FF_0000);

        // R6 single message
        do_reset();
        wtbl(8'h10, 32'h0000_A002);
        @(negedge clk); irq_in[0] = 1'b1;
        @(posedge clk); #1;
        check("R6 pend after first edge", 32'(pend_vec), 32'h04);
        check("R6 no message yet", 32'(msg_valid), 32'h0);
        @(posedge clk); #1;
        check("R6 msg_valid", 32'(msg_valid), 32'h1);
        check("R6 msg_addr", msg_addr, 32'hFFFB_0000);
        check("R6 msg_data", msg_data, 32'h2);
        repeat (3) @(posedge clk);
        #1;
        check("R12 held valid", 32'(msg_valid), 32'h1);
        check("R12 held addr", msg_addr, 32'hFFFB_0000);
        @(negedge clk); msg_ready = 1'b1;
        @(posedge clk); #1;
        check("R12 consumed", 32'(msg_valid), 32'h0);
        @(negedge clk); msg_ready = 1'b0;

        // R8 same pending bit already set
        wtbl(8'h12, 32'h0000_A00A);
        @(negedge clk); irq_in[1] = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R8 no second message", 32'(msg_valid), 32'h0);
        check("R8 pend unchanged", 32'(pend_vec), 32'h04);

        // R9 falling input clears its bit
        @(negedge clk); irq_in[1] = 1'b0;
        @(posedge clk); #1;
        check("R9 fall clears", 32'(pend_vec), 32'h00);

        // R10 end of interrupt
        @(negedge clk); irq_in[0] = 1'b0;
        @(negedge clk); irq_in[0] = 1'b1; msg_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); msg_ready = 1'b0;
        check("R10 pend before EOI", 32'(pend_vec), 32'h04);
        wreg(12'h840, 32'h03);
        check("R10 mismatched EOI", 32'(pend_vec), 32'h04);
        wreg(12'h840, 32'h42);
        check("R10 EOI clears", 32'(pend_vec), 32'h00);
        @(negedge clk); irq_in[0] = 1'b0;

        // R7 masked input and zero destination
        @(negedge clk); irq_in[2] = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R7 masked no message", 32'(msg_valid), 32'h0);
        check("R7 masked no pend", 32'(pend_vec), 32'h00);
        wtbl(8'h16, 32'h0000_A005);
        wtbl(8'h17, 32'h0);
        @(negedge clk); irq_in[3] = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R7 zero dest no message", 32'(msg_valid), 32'h0);
        check("R7 zero dest no pend", 32'(pend_vec), 32'h00);

        // R12 ordering of two waiting messages
        wtbl(8'h18, 32'h0000_A006);
        wtbl(8'h1A, 32'h0000_A007);
        @(negedge clk); irq_in[5:4] = 2'b11;
        @(posedge clk); @(posedge clk); #1;
        check("R8 two pend bits", 32'(pend_vec), 32'hC0);
        check("R12 first is lower index", msg_data, 32'h6);
        @(negedge clk); msg_ready = 1'b1;
        @(posedge clk); #1;
        check("R12 second valid", 32'(msg_valid), 32'h1);
        check("R12 second data", msg_data, 32'h7);
        @(posedge clk); #1;
        check("R12 drained", 32'(msg_valid), 32'h0);
        @(negedge clk); msg_ready = 1'b0;

        // R11 pack block and custom destination
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a;
            a = {4'hF, 8'(8'h12 + k * 8'h31), 8'(8'hA5 ^ (k * 8'h17)), 12'h000};
            pk_a = a;
            #1;
            check("R11 pack", pk_p, {a[19:12], a[27:20], 16'h0});
            check("R11 round trip", unpk(pk_p), a);
        end
        wtbl(8'h1D, 32'h3412_0000);
        wtbl(8'h1C, 32'h0000_A00B);
        @(negedge clk); irq_in[6] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R11 message address", msg_addr, 32'hF123_4000);
        check("R6 message vector", msg_data, 32'h0B);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule